// File: doc/BRIEF.md
# Key-Guarded Sequence Instruction Table

This block holds the instruction table that a serial memory sequencer walks through: 128 words of 32 bits, grouped as 32 sequences of four words each. Software fills the table through a small register-bus slave (address, write data, write enable, read data). The sequencer pulls a whole sequence at once through a separate read port that takes a sequence index.

A guard prevents stray writes from corrupting the table. The table can be locked, and while it is locked every table write is dropped. Changing the lock state is a two-step ritual. First, the magic value 0x5AF05AF0 goes to the key register at offset 0x18. Then the very next register write goes to the lock control register at offset 0x1C: 0x1 locks, 0x2 unlocks. Any other write in between cancels the key, so the key has to be written again before every lock or unlock command.

Top module: `lut_keyed_regfile`

## Requirements
- R1: After reset the table is unlocked, the key is not armed, and every table word reads 0 through the bus and through the sequencer port.
- R2: While unlocked, a write to byte offset 0x200 + s*16 + w*4 stores the data in word w of sequence s. A bus read of that offset returns the stored word one cycle after the address is presented.
- R3: Writing 0x5AF05AF0 to offset 0x18, and then writing 0x1 to offset 0x1C on the next bus write, locks the table.
- R4: A write to offset 0x1C that does not directly follow a correct key write leaves the lock state unchanged.
- R5: A correct key arms the lock control for exactly one following write. Any other write in between, including a table write, disarms it.
- R6: Writing any value other than 0x5AF05AF0 to offset 0x18 does not arm the lock control.
- R7: While locked, table writes are dropped, and bus reads still return the stored contents.
- R8: Writing the correct key and then 0x2 to offset 0x1C unlocks the table, after which table writes take effect again. Writing 0x2 without the key leaves the table locked.
- R9: A bus read of offset 0x1C returns 0x1 while locked and 0x2 while unlocked. Reads of offset 0x18 and of unmapped offsets return 0.
- R10: The sequencer port returns all four words of the selected sequence one cycle after the index is presented, with word w on bits [32*w+31:32*w].
- R11: An armed write to offset 0x1C with a value other than 0x1 or 0x2 leaves the lock state unchanged and consumes the arming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write enable, one write per cycle |
| reg_rdata | output | 32 | Read data for the address presented on the previous cycle |
| seq_sel | input | 5 | Sequence index for the sequencer port |
| seq_words | output | 128 | The four words of the selected sequence, word 0 in the low bits |

## Verification
A write takes effect at the edge that samples it. Lock state, arming and table contents therefore change on that edge. A bus read or a sequencer read returns its data one cycle after the address or index is applied. The bench drives every input on the falling edge and samples on the next falling edge, which is exactly one rising edge later. Each read result is checked in the cycle it becomes due. A lock command that should be ignored is checked by reading the lock control register back. A dropped table write is checked by reading the affected word back.

// File: rtl/lkr_pkg.sv
package lkr_pkg;
    localparam int unsigned KEY_OFS  = 32'h018;
    localparam int unsigned LOCK_OFS = 32'h01C;
    localparam int unsigned TBL_BASE = 32'h200;

    localparam logic [31:0] KEY_VAL    = 32'h5AF0_5AF0;
    localparam logic [31:0] CMD_LOCK   = 32'h0000_0001;
    localparam logic [31:0] CMD_UNLOCK = 32'h0000_0002;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_KEY  = 2'd1,
        SEL_LOCK = 2'd2,
        SEL_TBL  = 2'd3
    } sel_e;

    typedef struct packed {
        logic armed;
        logic locked;
    } guard_t;
endpackage

// File: rtl/lkr_decode.sv
module lkr_decode
    import lkr_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 128,
    parameter int IDX_W     = 7
) (
    input  logic [ADDR_W-1:0] addr_i,
    output sel_e              sel_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam int unsigned SPAN = NUM_WORDS * 4;

    logic [31:0] a32;
    logic [31:0] off;

    always_comb begin
        a32   = 32'(addr_i);
        off   = a32 - TBL_BASE;
        idx_o = off[IDX_W+1:2];
        if (a32 == KEY_OFS) begin
            sel_o = SEL_KEY;
        end else if (a32 == LOCK_OFS) begin
            sel_o = SEL_LOCK;
        end else if (a32 >= TBL_BASE && off < SPAN && off[1:0] == 2'b00) begin
            sel_o = SEL_TBL;
        end else begin
            sel_o = SEL_NONE;
        end
    end
endmodule

// File: rtl/lkr_guard.sv
module lkr_guard
    import lkr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  sel_e              sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              locked_o
);
    guard_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (we_i) begin
            g_d.armed = 1'b0;
            case (sel_i)
                SEL_KEY:  g_d.armed = (wdata_i == DATA_W'(KEY_VAL));
                SEL_LOCK: begin
                    if (g_q.armed) begin
                        if (wdata_i == DATA_W'(CMD_LOCK)) begin
                            g_d.locked = 1'b1;
                        end else if (wdata_i == DATA_W'(CMD_UNLOCK)) begin
                            g_d.locked = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign locked_o = g_q.locked;

    // R4: the lock state moves only on an armed lock-control write
    p_lock_change_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.locked != $past(g_q.locked)) |-> $past(g_q.armed && we_i && sel_i == SEL_LOCK));

    // R5: arming survives no write other than another key write
    p_arm_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.armed && we_i && sel_i != SEL_KEY) |=> !g_q.armed);

    // R6: a wrong key leaves the guard disarmed
    p_wrong_key_disarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && sel_i == SEL_KEY && wdata_i != DATA_W'(KEY_VAL)) |=> !g_q.armed);

    // R3: an armed lock command locks
    p_armed_lock_locks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.armed && we_i && sel_i == SEL_LOCK && wdata_i == DATA_W'(CMD_LOCK)) |=> g_q.locked);
endmodule

// File: rtl/lkr_table.sv
module lkr_table #(
    parameter int DATA_W    = 32,
    parameter int NUM_SEQ   = 32,
    parameter int SEQ_WORDS = 4,
    parameter int NUM_WORDS = NUM_SEQ * SEQ_WORDS,
    parameter int IDX_W     = $clog2(NUM_WORDS),
    parameter int SEQ_W     = $clog2(NUM_SEQ)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_req_i,
    input  logic                        locked_i,
    input  logic [IDX_W-1:0]            wr_idx_i,
    input  logic [DATA_W-1:0]           wdata_i,
    input  logic [IDX_W-1:0]            rd_idx_i,
    input  logic [SEQ_W-1:0]            seq_idx_i,
    output logic [DATA_W-1:0]           rd_word_o,
    output logic [SEQ_WORDS*DATA_W-1:0] seq_words_o
);
    typedef struct packed {
        logic [DATA_W-1:0]           rd;
        logic [SEQ_WORDS*DATA_W-1:0] seq;
    } out_t;

    logic [DATA_W-1:0] mem_d [NUM_WORDS];
    logic [DATA_W-1:0] mem_q [NUM_WORDS];
    logic [SEQ_WORDS*DATA_W-1:0] seq_gather;
    out_t out_d, out_q;
    logic wr_go;

    assign wr_go = wr_req_i && !locked_i;

    for (genvar w = 0; w < SEQ_WORDS; w++) begin : g_gather
        assign seq_gather[w*DATA_W +: DATA_W] =
            mem_q[IDX_W'(int'(seq_idx_i) * SEQ_WORDS + w)];
    end

    always_comb begin
        for (int i = 0; i < NUM_WORDS; i++) mem_d[i] = mem_q[i];
        if (wr_go) mem_d[wr_idx_i] = wdata_i;
        out_d.rd  = mem_q[rd_idx_i];
        out_d.seq = seq_gather;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= '0;
            out_q <= '0;
        end else begin
            for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= mem_d[i];
            out_q <= out_d;
        end
    end

    assign rd_word_o   = out_q.rd;
    assign seq_words_o = out_q.seq;

    // R2: an unlocked table write lands at its word
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && !locked_i) |=> mem_q[$past(wr_idx_i)] == $past(wdata_i));

    // R7: a locked table write leaves its word untouched
    p_locked_write_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_i && locked_i) |=> mem_q[$past(wr_idx_i)] == $past(mem_q[wr_idx_i]));
endmodule

// File: rtl/lut_keyed_regfile.sv
module lut_keyed_regfile
    import lkr_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_SEQ   = 32,
    parameter int SEQ_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W-1:0]           reg_wdata,
    input  logic                        reg_we,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic [$clog2(NUM_SEQ)-1:0]  seq_sel,
    output logic [SEQ_WORDS*DATA_W-1:0] seq_words
);
    localparam int NUM_WORDS = NUM_SEQ * SEQ_WORDS;
    localparam int IDX_W     = $clog2(NUM_WORDS);
    localparam int SEQ_W     = $clog2(NUM_SEQ);

    typedef struct packed {
        sel_e sel;
        logic locked;
    } rview_t;

    sel_e              sel;
    logic [IDX_W-1:0]  idx;
    logic              locked;
    logic [DATA_W-1:0] tbl_word;
    rview_t            rv_d, rv_q;

    lkr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS),
        .IDX_W    (IDX_W)
    ) u_decode (
        .addr_i(reg_addr),
        .sel_o (sel),
        .idx_o (idx)
    );

    lkr_guard #(
        .DATA_W(DATA_W)
    ) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .sel_i   (sel),
        .wdata_i (reg_wdata),
        .locked_o(locked)
    );

    lkr_table #(
        .DATA_W   (DATA_W),
        .NUM_SEQ  (NUM_SEQ),
        .SEQ_WORDS(SEQ_WORDS),
        .NUM_WORDS(NUM_WORDS),
        .IDX_W    (IDX_W),
        .SEQ_W    (SEQ_W)
    ) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req_i   (reg_we && sel == SEL_TBL),
        .locked_i   (locked),
        .wr_idx_i   (idx),
        .wdata_i    (reg_wdata),
        .rd_idx_i   (idx),
        .seq_idx_i  (seq_sel),
        .rd_word_o  (tbl_word),
        .seq_words_o(seq_words)
    );

    always_comb begin
        rv_d.sel    = sel;
        rv_d.locked = locked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rv_q <= '0;
        else        rv_q <= rv_d;
    end

    always_comb begin
        case (rv_q.sel)
            SEL_TBL:  reg_rdata = tbl_word;
            SEL_LOCK: reg_rdata = rv_q.locked ? DATA_W'(CMD_LOCK) : DATA_W'(CMD_UNLOCK);
            default:  reg_rdata = '0;
        endcase
    end

    // R9: key and unmapped offsets never return data
    p_quiet_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_KEY || sel == SEL_NONE) |=> reg_rdata == '0);
endmodule

// File: tb/lut_keyed_regfile_bench.sv
`timescale 1ns/1ps
module lut_keyed_regfile_bench;
    localparam logic [31:0] KEY = 32'h5AF0_5AF0;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [11:0]  reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic         reg_we = 1'b0;
    logic [31:0]  reg_rdata;
    logic [4:0]   seq_sel = '0;
    logic [127:0] seq_words;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    lut_keyed_regfile u_lut_keyed_regfile (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .seq_sel(seq_sel), .seq_words(seq_words)
    );

    typedef struct packed {
        logic        rd;
        logic [11:0] addr;
        logic [31:0] data;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h200, 32'h1111_1111, 8'd2},   // R2
        '{1'b0, 12'h204, 32'h2222_2222, 8'd2},
        '{1'b0, 12'h3FC, 32'hDEAD_BEEF, 8'd2},
        '{1'b1, 12'h200, 32'h1111_1111, 8'd2},
        '{1'b1, 12'h3FC, 32'hDEAD_BEEF, 8'd2},
        '{1'b1, 12'h01C, 32'h0000_0002, 8'd9},   // R9 unlocked
        '{1'b0, 12'h01C, 32'h0000_0001, 8'd4},   // R4 lock without key
        '{1'b1, 12'h01C, 32'h0000_0002, 8'd4},
        '{1'b0, 12'h018, 32'h5AF0_5AF1, 8'd6},   // R6 wrong key
        '{1'b0, 12'h01C, 32'h0000_0001, 8'd6},
        '{1'b1, 12'h01C, 32'h0000_0002, 8'd6},
        '{1'b0, 12'h018, KEY,           8'd5},   // R5 intervening write
        '{1'b0, 12'h200, 32'h0000_0005, 8'd5},
        '{1'b0, 12'h01C, 32'h0000_0001, 8'd5},
        '{1'b1, 12'h01C, 32'h0000_0002, 8'd5},
        '{1'b0, 12'h018, KEY,           8'd11},  // R11 bad command
        '{1'b0, 12'h01C, 32'h0000_0003, 8'd11},
        '{1'b1, 12'h01C, 32'h0000_0002, 8'd11},
        '{1'b0, 12'h01C, 32'h0000_0001, 8'd11},
        '{1'b1, 12'h01C, 32'h0000_0002, 8'd11},
        '{1'b0, 12'h018, KEY,           8'd3},   // R3 lock
        '{1'b0, 12'h01C, 32'h0000_0001, 8'd3},
        '{1'b1, 12'h01C, 32'h0000_0001, 8'd3},
        '{1'b0, 12'h204, 32'h0000_0099, 8'd7},   // R7 dropped
        '{1'b1, 12'h204, 32'h2222_2222, 8'd7},
        '{1'b1, 12'h018, 32'h0000_0000, 8'd9},   // R9 key reads 0
        '{1'b1, 12'h100, 32'h0000_0000, 8'd9},
        '{1'b0, 12'h01C, 32'h0000_0002, 8'd8},   // R8 unlock without key
        '{1'b1, 12'h01C, 32'h0000_0001, 8'd8},
        '{1'b1, 12'h200, 32'h0000_0005, 8'd7}
    };

    task automatic check(input logic [127:0] got, input logic [127:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a; reg_we = 1'b0;
        @(negedge clk);
        check(128'(reg_rdata), 128'(exp), tag);
    endtask

    task automatic seq_rd(input logic [4:0] s, input logic [127:0] exp, input string tag);
        seq_sel = s;
        @(negedge clk);
        check(seq_words, exp, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(12'h01C, 32'h2, "R1 lock reads unlocked");
        rd(12'h200, 32'h0, "R1 word zero");
        rd(12'h3FC, 32'h0, "R1 last word zero");
        seq_rd(5'd0, 128'h0, "R1 seq zero");
        seq_rd(5'd31, 128'h0, "R1 last seq zero");
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) rd(VECS[i].addr, VECS[i].data, $sformatf("R%0d vec %0d", VECS[i].req, i));
            else            wr(VECS[i].addr, VECS[i].data);
        end
        // R8: proper unlock, then writes work again
        wr(12'h018, KEY);
        wr(12'h01C, 32'h2);
        rd(12'h01C, 32'h2, "R8 unlocked");
        wr(12'h204, 32'h77);
        rd(12'h204, 32'h77, "R8 write after unlock");
        // R10: sequencer port layout and latency
        seq_rd(5'd0, {32'h0, 32'h0, 32'h77, 32'h5}, "R10 seq 0");
        seq_rd(5'd31, {32'hDEAD_BEEF, 96'h0}, "R10 seq 31");
        wr(12'h228, 32'hA5A5_0001);
        seq_rd(5'd2, {32'h0, 32'hA5A5_0001, 64'h0}, "R10 seq 2 word 2");
        // R5: a second key write keeps arming, then lock command works
        wr(12'h018, KEY);
        wr(12'h018, KEY);
        wr(12'h01C, 32'h1);
        rd(12'h01C, 32'h1, "R5 key rearm locks");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule